// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Transfer Watchdog

This block is the central controller of a shared parallel bus with several masters. Each master has a private request input and a private grant output. A master raises its request to ask for the bus and keeps it raised for the whole time it owns the bus. The arbiter takes the bus away from the owner only after that request falls. It then leaves the bus idle for one cycle and grants the next waiting master. Waiting masters are chosen in round-robin order, and the search starts just past the master that was served last.

The same controller also guards the bus against transfers that no slave answers. It counts clock cycles from the moment the bus transfer request line is raised. If no slave acknowledge arrives within a fixed window of 2000 ns, the controller drives an acknowledge and an error of its own, which ends the transfer as a failure. When the master withdraws its transfer request, the forced error is released first. The forced acknowledge is released one cycle after that. All inputs and outputs are active high, and the polarity of the external bus is handled outside this block.

Top module: `bus_arbiter_wd`

## Requirements
- R1: Master i is served through req_i[i] and gnt_o[i] alone, and at no time is more than one bit of gnt_o set.
- R2: When the bus is idle, a raised request is granted on the third rising clock edge after it is applied: two synchroniser stages, then the grant register.
- R3: While the owner keeps its request raised, its grant stays set, whatever other requests are present.
- R4: When the owner drops its request, its grant falls on the third rising edge after the drop. The next waiting master is granted on the fourth edge. The grant never moves directly from one master to another.
- R5: The search for the next master starts at the index one above the last owner, wrapping from N_MASTERS-1 to 0. After reset it starts at master 0.
- R6: During reset, and directly after it, gnt_o is all zeros and both forced outputs are low.
- R7: If xfer_req_i stays high with slv_ack_i low for TMO_CYC = TIMEOUT_NS/CLK_PERIOD_NS cycles (400 with the defaults), frc_ack_o and frc_err_o both rise on the TMO_CYC-th rising edge after xfer_req_i was raised.
- R8: A slave acknowledge that is present at or before the expiry edge prevents the forced outputs. They stay low for as long as that transfer request is held.
- R9: After a forced termination, frc_err_o falls on the first edge after xfer_req_i is dropped, and frc_ack_o falls on the edge after that.
- R10: If xfer_req_i drops before expiry, the count is cleared, so the next transfer request gets the full TMO_CYC window.
- R11: Once the forced outputs are set, a slave acknowledge that arrives late does not clear them. They stay set until xfer_req_i drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Per-master bus request, asynchronous |
| xfer_req_i | input | 1 | Bus transfer request line, synchronous to clk |
| slv_ack_i | input | 1 | Slave acknowledge line, synchronous to clk |
| gnt_o | output | N_MASTERS | Per-master bus grant, one-hot or zero |
| frc_ack_o | output | 1 | Forced acknowledge drive |
| frc_err_o | output | 1 | Forced error drive |

## Verification
Two watchdog events can land on the same clock edge: a real slave acknowledge and the expiry of the timeout count. The bench provokes this by raising slv_ack_i in the cycle just before the TMO_CYC-th edge. It then expects no forced outputs, which shows that the real answer takes priority. A second case raises the acknowledge one cycle later, after the force has already happened. There the forced outputs must stay set until xfer_req_i drops, and must then release in the order error first, acknowledge second.

// File: rtl/arb_pkg.sv
package arb_pkg;

   typedef enum logic [1:0] {
      WD_IDLE  = 2'd0,
      WD_HELD  = 2'd1,
      WD_FORCE = 2'd2,
      WD_TAIL  = 2'd3
   } wd_state_t;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES == 1) begin : g_bad_stages
      $error("arb_sync: STAGES must be 0 or at least 2");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
               chain_q[s] <= chain_q[s-1];
            end
         end
      end

      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/arb_rr_core.sv
module arb_rr_core #(
   parameter int N_MASTERS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_s,
   output logic [N_MASTERS-1:0] gnt_o
);

   localparam int IDXW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

   logic [N_MASTERS-1:0] gnt_q;
   logic [IDXW-1:0]      owner_q;
   logic                 owner_vld_q;
   logic [IDXW-1:0]      ptr_q;
   logic [IDXW-1:0]      pick_idx;
   logic                 pick_vld;
   logic [IDXW-1:0]      next_ptr;

   always_comb begin
      pick_vld = 1'b0;
      pick_idx = '0;
      for (int k = 0; k < N_MASTERS; k++) begin
         int idx;
         idx = (int'(ptr_q) + k) % N_MASTERS;
         if (!pick_vld && req_s[idx]) begin
            pick_vld = 1'b1;
            pick_idx = IDXW'(idx);
         end
      end
   end

   assign next_ptr = (int'(owner_q) == N_MASTERS - 1) ? '0 : owner_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q       <= '0;
         owner_q     <= '0;
         owner_vld_q <= 1'b0;
         ptr_q       <= '0;
      end else if (owner_vld_q) begin
         if (!req_s[owner_q]) begin
            gnt_q       <= '0;
            owner_vld_q <= 1'b0;
            ptr_q       <= next_ptr;
         end
      end else if (pick_vld) begin
         gnt_q           <= '0;
         gnt_q[pick_idx] <= 1'b1;
         owner_q         <= pick_idx;
         owner_vld_q     <= 1'b1;
      end
   end

   assign gnt_o = gnt_q;

   AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (|(gnt_q & req_s)) |=> $stable(gnt_q)); // R3

   AST_NO_DIRECT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_q != '0) |=> ((gnt_q == '0) || $stable(gnt_q))); // R4

   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|gnt_q) |-> (|(gnt_q & $past(req_s)))); // R2

endmodule

// File: rtl/arb_watchdog.sv
module arb_watchdog
   import arb_pkg::*;
#(
   parameter int TMO_CYC = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_req_i,
   input  logic slv_ack_i,
   output logic frc_ack_o,
   output logic frc_err_o
);

   localparam int CNTW = $clog2(TMO_CYC + 1);
   localparam logic [CNTW-1:0] LAST = CNTW'(TMO_CYC - 1);

   wd_state_t       state_q;
   logic [CNTW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WD_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            WD_IDLE: begin
               if (!xfer_req_i) begin
                  cnt_q <= '0;
               end else if (slv_ack_i) begin
                  cnt_q   <= '0;
                  state_q <= WD_HELD;
               end else if (cnt_q == LAST) begin
                  cnt_q   <= '0;
                  state_q <= WD_FORCE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            WD_HELD: begin
               if (!xfer_req_i) state_q <= WD_IDLE;
            end
            WD_FORCE: begin
               if (!xfer_req_i) state_q <= WD_TAIL;
            end
            default: begin
               state_q <= WD_IDLE;
            end
         endcase
      end
   end

   assign frc_ack_o = (state_q == WD_FORCE) || (state_q == WD_TAIL);
   assign frc_err_o = (state_q == WD_FORCE);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R7

   AST_FORCE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frc_err_o) |-> $past(xfer_req_i && !slv_ack_i)); // R8

   AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      frc_err_o |-> frc_ack_o); // R9

   AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frc_err_o) |-> ($past(!xfer_req_i) && frc_ack_o)); // R9

   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frc_ack_o) |-> $past(!frc_err_o)); // R9

   AST_FORCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (frc_err_o && xfer_req_i) |=> frc_err_o); // R11

endmodule

// File: rtl/bus_arbiter_wd.sv
module bus_arbiter_wd #(
   parameter int N_MASTERS     = 4,
   parameter int SYNC_STAGES   = 2,
   parameter int CLK_PERIOD_NS = 5,
   parameter int TIMEOUT_NS    = 2000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_i,
   input  logic                 xfer_req_i,
   input  logic                 slv_ack_i,
   output logic [N_MASTERS-1:0] gnt_o,
   output logic                 frc_ack_o,
   output logic                 frc_err_o
);

   localparam int TMO_CYC = TIMEOUT_NS / CLK_PERIOD_NS;

   if (N_MASTERS < 2) begin : g_bad_masters
      $error("bus_arbiter_wd: N_MASTERS must be at least 2");
   end
   if (TMO_CYC < 2) begin : g_bad_timeout
      $error("bus_arbiter_wd: timeout must span at least 2 clock cycles");
   end

   logic [N_MASTERS-1:0] req_s;

   arb_sync #(
      .WIDTH  (N_MASTERS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (req_i),
      .q_o   (req_s)
   );

   arb_rr_core #(
      .N_MASTERS (N_MASTERS)
   ) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .req_s (req_s),
      .gnt_o (gnt_o)
   );

   arb_watchdog #(
      .TMO_CYC (TMO_CYC)
   ) u_wd (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_req_i (xfer_req_i),
      .slv_ack_i  (slv_ack_i),
      .frc_ack_o  (frc_ack_o),
      .frc_err_o  (frc_err_o)
   );

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o)); // R1

endmodule

// File: tb/sim_bus_arbiter_wd.sv
`timescale 1ns/1ps
module sim_bus_arbiter_wd;

   localparam int N   = 4;
   localparam int TMO = 2000 / 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic [N-1:0] req = '0;
   logic         xfer = 1'b0;
   logic         ack = 1'b0;
   logic [N-1:0] gnt;
   logic         frc_ack;
   logic         frc_err;

   int checks = 0;
   int errors = 0;
   int multi_gnt = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bus_arbiter_wd #(
      .N_MASTERS     (N),
      .SYNC_STAGES   (2),
      .CLK_PERIOD_NS (5),
      .TIMEOUT_NS    (2000)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req),
      .xfer_req_i (xfer),
      .slv_ack_i  (ack),
      .gnt_o      (gnt),
      .frc_ack_o  (frc_ack),
      .frc_err_o  (frc_err)
   );

   always @(negedge clk) begin
      if (rst_n && ($countones(gnt) > 1)) multi_gnt++;
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [N-1:0] oh(input int m);
      logic [N-1:0] v;
      v = '0;
      v[m] = 1'b1;
      return v;
   endfunction

   // R6: reset state
   task automatic t_reset();
      rst_n = 1'b0;
      step(3);
      chk("R6 gnt in reset", 32'(gnt), 0);
      chk("R6 frc in reset", {30'd0, frc_ack, frc_err}, 0);
      rst_n = 1'b1;
      step(1);
      chk("R6 gnt after reset", 32'(gnt), 0);
   endtask

   // R2, R5: idle grant latency, pointer starts at 0
   task automatic t_single();
      req[2] = 1'b1;
      step(2);
      chk("R2 not yet granted", 32'(gnt), 0);
      step(1);
      chk("R2 granted on third edge", 32'(gnt), 32'(oh(2)));
      req[2] = 1'b0;
      step(3);
      chk("R4 grant removed", 32'(gnt), 0);
   endtask

   // R3 hold, R4 handover timing, R5 search past owner
   task automatic t_hold_handover();
      req[1] = 1'b1;
      step(3);
      chk("R5 search from 3 finds 1", 32'(gnt), 32'(oh(1)));
      req[3] = 1'b1;
      step(20);
      chk("R3 owner keeps grant", 32'(gnt), 32'(oh(1)));
      req[1] = 1'b0;
      step(2);
      chk("R4 grant held 2 edges after drop", 32'(gnt), 32'(oh(1)));
      step(1);
      chk("R4 idle gap", 32'(gnt), 0);
      step(1);
      chk("R4 next master granted", 32'(gnt), 32'(oh(3)));
      req[3] = 1'b0;
      step(4);
      chk("R4 bus idle", 32'(gnt), 0);
   endtask

   // R5 round-robin order with all requesting
   task automatic t_rr_all();
      req = '1;
      step(3);
      chk("R5 first of all is 0", 32'(gnt), 32'(oh(0)));
      for (int m = 0; m < N - 1; m++) begin
         req[m] = 1'b0;
         step(4);
         chk("R5 rotation order", 32'(gnt), 32'(oh(m + 1)));
      end
      req[N-1] = 1'b0;
      step(4);
      req[3] = 1'b1;
      req[1] = 1'b1;
      step(3);
      chk("R5 wrap then pick 1 over 3", 32'(gnt), 32'(oh(1)));
      req = '0;
      step(4);
   endtask

   // R7, R9: timeout and release order
   task automatic t_timeout();
      xfer = 1'b1;
      step(TMO - 1);
      chk("R7 no force before window", {30'd0, frc_ack, frc_err}, 0);
      step(1);
      chk("R7 force at window", {30'd0, frc_ack, frc_err}, 3);
      step(5);
      xfer = 1'b0;
      step(1);
      chk("R9 err released first", {30'd0, frc_ack, frc_err}, 2);
      step(1);
      chk("R9 ack released next", {30'd0, frc_ack, frc_err}, 0);
   endtask

   // R8: ack in the expiry cycle wins
   task automatic t_ack_race();
      xfer = 1'b1;
      step(TMO - 1);
      ack = 1'b1;
      step(1);
      chk("R8 ack on expiry edge", {30'd0, frc_ack, frc_err}, 0);
      ack = 1'b0;
      step(TMO + 5);
      chk("R8 held transfer not forced", {30'd0, frc_ack, frc_err}, 0);
      xfer = 1'b0;
      step(2);
   endtask

   // R10: early drop restarts the window
   task automatic t_restart();
      xfer = 1'b1;
      step(TMO - 5);
      xfer = 1'b0;
      step(2);
      xfer = 1'b1;
      step(TMO - 1);
      chk("R10 full window again", {30'd0, frc_ack, frc_err}, 0);
      step(1);
      chk("R10 force after full window", {30'd0, frc_ack, frc_err}, 3);
   endtask

   // R11: late ack does not clear force (continues from t_restart)
   task automatic t_late_ack();
      ack = 1'b1;
      step(3);
      chk("R11 force kept with late ack", {30'd0, frc_ack, frc_err}, 3);
      xfer = 1'b0;
      step(1);
      chk("R11 R9 err drop after request drop", {30'd0, frc_ack, frc_err}, 2);
      ack = 1'b0;
      step(1);
      chk("R11 R9 ack drop", {30'd0, frc_ack, frc_err}, 0);
   endtask

   initial begin
      #1;
      t_reset();
      t_single();
      t_hold_handover();
      t_rr_all();
      t_timeout();
      t_ack_race();
      t_restart();
      t_late_ack();
      chk("R1 never two grants", multi_gnt, 0);
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule